// File: doc/BRIEF.md
# Interrupt Autovector Response Logic

This block decides, for each interrupt acknowledge cycle on an external level, whether the response is an internally generated autovector. A small mask register holds one enable bit per external priority level. While an acknowledge is in progress, the block asserts its autovector strobe if three things hold: the mask bit for the acknowledged level is set, the level is nonzero, and the block's arbitration ID is nonzero.

The block also contends with a peer peripheral source whose arbitration ID is fixed at 8. The block wins against that peer only when its own ID is strictly greater than 8. An ID of 0 never wins. A tie goes to the peer.

Only supervisor-mode code may access the mask register. A user-mode access changes nothing, reads back as zero, and raises a one-cycle access-error pulse.

The acknowledge sequencer has three states:
- `S_IDLE`: no acknowledge is in progress.
- `S_AUTO`: an acknowledge is in progress and the block responds with an autovector.
- `S_PASS`: an acknowledge is in progress and the block does not autovector.

The sequencer has three transitions:
- **T_HIT** (`S_IDLE` to `S_AUTO`): taken when the strobe is seen high and the autovector conditions hold.
- **T_MISS** (`S_IDLE` to `S_PASS`): taken when the strobe is seen high and the conditions fail.
- **T_DONE** (`S_AUTO` or `S_PASS` to `S_IDLE`): taken when the strobe is seen low.

The level, the autovector decision and the arbitration result are all captured at T_HIT or T_MISS.

Top module: `irq_autovec`

## Requirements
- R1: After reset the mask register reads 0x00, and `avec`, `arb_win` and `acc_err` are low.
- R2: A supervisor write (`reg_sel`=1, `reg_we`=1, `supv`=1) loads bits 7..1 of `reg_wdata` into the mask at the clock edge. Bit n enables level n. Bit 0 always reads 0.
- R3: While `reg_sel`=1 and `supv`=1, `reg_rdata` shows the current mask in the same cycle. Otherwise `reg_rdata` is 0.
- R4: An access with `reg_sel`=1 and `supv`=0 leaves the mask unchanged and reads 0. It makes `acc_err` high for exactly the following cycle.
- R5: If `iack` rises with level L in 1..7, mask bit L set and `arb_id` nonzero, then `avec` is high from the cycle after the rise for as long as `iack` stays high.
- R6: With `arb_id` = 0 at the start of an acknowledge, `avec` stays low for that whole acknowledge.
- R7: An acknowledge for level 0, or for a level whose mask bit is clear, gives no `avec`.
- R8: `avec` and `arb_win` are never high while `iack` is low. They drop in the same cycle that `iack` falls.
- R9: During an acknowledge, `arb_win` is high if and only if `arb_id` > 8 at the start of the acknowledge. For example, 0xF wins, while 0x1, 0x8 and 0x0 lose.
- R10: Once an acknowledge has started, changes on `iack_lvl` or `arb_id` do not alter `avec` or `arb_win` until `iack` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Mask register access strobe |
| reg_we | input | 1 | Write enable for the access |
| reg_wdata | input | 8 | Write data |
| supv | input | 1 | Supervisor-mode flag of the access |
| reg_rdata | output | 8 | Read data (combinational) |
| acc_err | output | 1 | One-cycle pulse after a user-mode access |
| iack | input | 1 | Interrupt acknowledge strobe |
| iack_lvl | input | 3 | Acknowledged priority level |
| arb_id | input | 4 | Arbitration ID of this block |
| avec | output | 1 | Autovector response strobe |
| arb_win | output | 1 | This block beats the ID-8 peer |

## Verification
The bench targets the gating corners:
- **ID 0 with the level enabled.** A design that ignores the ID check would autovector here.
- **Level 0.** A design that indexes the mask without a range check would respond from the unused bit.
- **ID exactly 8.** A design with an off-by-one comparison would claim a win on the tie.

It also covers three timing and access corners:
- **User-mode writes.** A design that misses the privilege check would corrupt the mask.
- **Level and ID changing mid-acknowledge.** A design that decodes live inputs would flip `avec` or `arb_win` partway through the cycle.
- **The falling strobe.** A design whose outputs are purely registered would hold `avec` one cycle into the idle bus.

// File: rtl/avec_pkg.sv
package avec_pkg;
    localparam int LVL_W_DEF   = 3;
    localparam int ID_W_DEF    = 4;
    localparam int PEER_ID_DEF = 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_AUTO = 2'd1,
        S_PASS = 2'd2
    } ack_state_t;
endpackage

// File: rtl/avec_mask_reg.sv
module avec_mask_reg #(
    parameter int NLVL = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            we,
    input  logic            supv,
    input  logic [NLVL-1:0] wdata,
    output logic [NLVL-1:0] rdata,
    output logic            acc_err,
    output logic [NLVL-1:0] mask_o
);
    logic priv_ok;
    logic user_hit;

    assign priv_ok  = sel && supv;
    assign user_hit = sel && !supv;

    for (genvar i = 0; i < NLVL; i++) begin : g_bit
        if (i == 0) begin : g_unused
            assign mask_o[i] = 1'b0;
        end else begin : g_level
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (priv_ok && we)
                    bit_q <= wdata[i];
            end
            assign mask_o[i] = bit_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_err <= 1'b0;
        else
            acc_err <= user_hit;
    end

    assign rdata = priv_ok ? mask_o : '0;
endmodule

// File: rtl/avec_arb.sv
module avec_arb #(
    parameter int ID_W    = 4,
    parameter int PEER_ID = 8
) (
    input  logic [ID_W-1:0] id,
    output logic            id_ok,
    output logic            win
);
    localparam logic [ID_W-1:0] PEER = ID_W'(PEER_ID);

    assign id_ok = (id != '0);
    assign win   = id_ok && (id > PEER);
endmodule

// File: rtl/avec_ack_fsm.sv
module avec_ack_fsm
    import avec_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int NLVL  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack,
    input  logic [LVL_W-1:0] lvl,
    input  logic [NLVL-1:0]  mask,
    input  logic             id_ok,
    input  logic             win,
    output logic             avec,
    output logic             arb_win
);
    ack_state_t state_q, state_d;
    logic       win_q;
    logic       hit;

    assign hit = (lvl != '0) && mask[lvl] && id_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (iack) state_d = hit ? S_AUTO : S_PASS;
            S_AUTO: if (!iack) state_d = S_IDLE;
            S_PASS: if (!iack) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            win_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && iack)
                win_q <= win;
        end
    end

    always_comb begin
        avec    = 1'b0;
        arb_win = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_AUTO: begin
                avec    = iack;
                arb_win = iack && win_q;
            end
            S_PASS: arb_win = iack && win_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_autovec.sv
module irq_autovec
    import avec_pkg::*;
#(
    parameter int LVL_W   = LVL_W_DEF,
    parameter int ID_W    = ID_W_DEF,
    parameter int PEER_ID = PEER_ID_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_we,
    input  logic [(1<<LVL_W)-1:0] reg_wdata,
    input  logic                 supv,
    output logic [(1<<LVL_W)-1:0] reg_rdata,
    output logic                 acc_err,
    input  logic                 iack,
    input  logic [LVL_W-1:0]     iack_lvl,
    input  logic [ID_W-1:0]      arb_id,
    output logic                 avec,
    output logic                 arb_win
);
    localparam int NLVL = 1 << LVL_W;

    logic [NLVL-1:0] mask;
    logic            id_ok;
    logic            win;

    avec_mask_reg #(.NLVL(NLVL)) u_mask (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we), .supv(supv),
        .wdata(reg_wdata), .rdata(reg_rdata), .acc_err(acc_err), .mask_o(mask)
    );

    avec_arb #(.ID_W(ID_W), .PEER_ID(PEER_ID)) u_arb (
        .id(arb_id), .id_ok(id_ok), .win(win)
    );

    avec_ack_fsm #(.LVL_W(LVL_W), .NLVL(NLVL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .iack(iack), .lvl(iack_lvl), .mask(mask),
        .id_ok(id_ok), .win(win), .avec(avec), .arb_win(arb_win)
    );
endmodule

// File: rtl/irq_autovec_chk.sv
module irq_autovec_chk #(
    parameter int LVL_W = 3,
    parameter int ID_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_sel,
    input logic                  supv,
    input logic [(1<<LVL_W)-1:0] reg_rdata,
    input logic                  acc_err,
    input logic                  iack,
    input logic [LVL_W-1:0]      iack_lvl,
    input logic [ID_W-1:0]       arb_id,
    input logic                  avec,
    input logic                  arb_win
);
    AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[0] == 1'b0); // R2
    AST_USER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_sel && !supv) |-> reg_rdata == '0); // R4
    AST_ERR_AFTER_USER: assert property (@(posedge clk) disable iff (!rst_n) (reg_sel && !supv) |=> acc_err); // R4
    AST_ERR_ONLY_USER: assert property (@(posedge clk) disable iff (!rst_n) (!reg_sel || supv) |=> !acc_err); // R4
    AST_AVEC_NEEDS_IACK: assert property (@(posedge clk) disable iff (!rst_n) avec |-> iack); // R8
    AST_WIN_NEEDS_IACK: assert property (@(posedge clk) disable iff (!rst_n) arb_win |-> iack); // R8
    AST_NO_AVEC_ID0: assert property (@(posedge clk) disable iff (!rst_n) ($rose(iack) && arb_id == '0) |=> !avec); // R6
    AST_NO_AVEC_LVL0: assert property (@(posedge clk) disable iff (!rst_n) ($rose(iack) && iack_lvl == '0) |=> !avec); // R7
    AST_LOW_ID_LOSES: assert property (@(posedge clk) disable iff (!rst_n) ($rose(iack) && arb_id <= ID_W'(8)) |=> !arb_win); // R9
    AST_AVEC_HELD: assert property (@(posedge clk) disable iff (!rst_n) (avec && iack) |=> (avec || !iack)); // R10
endmodule

bind irq_autovec irq_autovec_chk #(.LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .supv(supv),
    .reg_rdata(reg_rdata), .acc_err(acc_err), .iack(iack),
    .iack_lvl(iack_lvl), .arb_id(arb_id), .avec(avec), .arb_win(arb_win)
);

// File: tb/irq_autovec_tb.sv
module irq_autovec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_we = 1'b0, supv = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       acc_err, iack = 1'b0, avec, arb_win;
    logic [2:0] iack_lvl = '0;
    logic [3:0] arb_id = '0;

    int checks = 0, errors = 0;
    logic [7:0] mask_m = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_autovec u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .supv(supv), .reg_rdata(reg_rdata),
        .acc_err(acc_err), .iack(iack), .iack_lvl(iack_lvl), .arb_id(arb_id),
        .avec(avec), .arb_win(arb_win)
    );

    function automatic logic exp_avec(logic [7:0] m, logic [2:0] l, logic [3:0] id);
        return (l != 0) && m[l] && (id != 0);
    endfunction

    function automatic logic exp_win(logic [3:0] id);
        return id > 4'd8;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic s, logic [7:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 1; supv = s; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_we = 0;
        if (s) mask_m = {d[7:1], 1'b0};
        chk(s ? "R2 no-err" : "R4 acc_err", {31'b0, acc_err}, {31'b0, !s});
        @(negedge clk);
        chk("R4 err one cycle", {31'b0, acc_err}, 0);
    endtask

    task automatic rd(logic s);
        @(negedge clk);
        reg_sel = 1; reg_we = 0; supv = s;
        #1 chk(s ? "R3 read" : "R4 user read zero", reg_rdata, s ? mask_m : 8'h00);
        @(negedge clk);
        reg_sel = 0;
        chk(s ? "R3 no-err" : "R4 acc_err", {31'b0, acc_err}, {31'b0, !s});
    endtask

    task automatic ack(logic [2:0] l, logic [3:0] id, int hold, string req);
        logic ea, ew;
        ea = exp_avec(mask_m, l, id);
        ew = exp_win(id);
        @(negedge clk);
        iack = 1; iack_lvl = l; arb_id = id;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk({req, " avec"}, {31'b0, avec}, {31'b0, ea});
            chk("R9 arb_win", {31'b0, arb_win}, {31'b0, ew});
            iack_lvl = 3'($urandom_range(0, 7));
            arb_id = 4'($urandom_range(0, 15));
        end
        iack = 0;
        #1 chk("R8 avec drop", {31'b0, avec}, 0);
        chk("R8 win drop", {31'b0, arb_win}, 0);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        reg_sel = 1; supv = 1;
        #1 chk("R1 reset mask", reg_rdata, 8'h00);
        reg_sel = 0;
        chk("R1 reset outs", {avec, arb_win, acc_err}, 0);
        @(negedge clk);

        wr(1, 8'hFF); rd(1);                 // R2 bit0 cleared
        wr(0, 8'h00); rd(1);                 // R4 user write ignored
        rd(0);
        ack(3'd5, 4'hF, 3, "R5 hit");        // R10 changes mid-ack
        ack(3'd5, 4'h0, 2, "R6 id0");
        ack(3'd0, 4'hF, 2, "R7 lvl0");
        ack(3'd3, 4'h8, 2, "R9 tie");
        ack(3'd3, 4'h1, 2, "R9 low");
        wr(1, 8'b1010_0100);
        ack(3'd3, 4'h9, 2, "R7 masked");
        ack(3'd2, 4'h9, 2, "R5 hit2");

        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 3);
            if (op == 0) wr(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
            else if (op == 1) rd(1'($urandom_range(0, 1)));
            else ack(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
                     $urandom_range(1, 4), "R5 rand");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule